// File: doc/BRIEF.md
# DRAM Refresh Cycle Decoder

This block is the device-side control logic of a dynamic RAM that decides, once per row-strobe cycle, what kind of cycle the controller has started. It watches the synchronized row strobe, the two column-strobe lanes (either one counts), the write enable and the latched row address. It reports a cycle-type code, and for every cycle that refreshes a row it gives a one-cycle refresh strobe with the row to refresh. It also holds the parallel test-mode flag.

A cycle whose column strobe was already low before the row strobe fell is a counter refresh. The row comes from an internal 12-bit counter, which then advances. If the column strobe was held low straight through from a previous access, that counter refresh is a hidden refresh. If write enable was also low before and at the fall, the cycle is test-mode entry. A cycle whose column strobe is high at the row strobe fall first refreshes the externally supplied row. It is reported as a row-only refresh until a column strobe arrives, and from then on as a normal access. When the row address is one bit wider than the counter, each counter refresh covers the row pair that differs only in the top bit, so 4096 counter refreshes cover 8192 rows.

All strobes are treated as sampled levels on the block clock. The edges are found by comparing each sample with the one before it.

Top module: `dram_cycle_classifier`

## Requirements
- R1: Synchronous reset sets the cycle code to idle (0), clears the refresh strobe and the test flag, and zeroes the counter, so the first counter refresh uses row 0.
- R2: A row strobe fall with a column strobe low both in the sample before and in the sample of the fall, and write enable not low in both, gives code counter refresh (3). The refresh strobe is high for exactly one cycle, with the row equal to the counter value. The counter then advances by one.
- R3: A row strobe fall with the column strobes high gives code row-only refresh (2) and a one-cycle refresh strobe with the row equal to the row address input. The counter is left as it was.
- R4: A column strobe low while the row strobe is low changes a row-only code to normal access (1) from the next sample and clears the test flag.
- R5: A column strobe that first goes low in the same sample as the row strobe fall does not meet setup. The cycle is treated as row-only and then as a normal access.
- R6: A column strobe held low across a row strobe rise and the following fall gives code hidden refresh (4), with the counter row and a counter advance.
- R7: Counter refresh conditions plus write enable low in the sample before and in the sample of the fall give code test entry (5). This sets the test flag, refreshes the counter row and advances the counter. Write enable low only in the fall sample gives a plain counter refresh (3).
- R8: Counter, hidden and row-only refreshes leave the test flag unchanged.
- R9: The code holds while the row strobe stays low and reads idle from the first sample after the row strobe is high.
- R10: The counter is 12 bits wide and wraps to 0 after 4095.
- R11: With a 13-bit row, a counter refresh drives the row top bit 0 and raises the pair flag. A row-only refresh lowers the pair flag.
- R12: Either column strobe lane alone is enough for every rule above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low, synchronized |
| cas_lo_n | input | 1 | Lower-lane column strobe, active low |
| cas_hi_n | input | 1 | Upper-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| row_addr | input | ROW_W | Latched external row address |
| cyc_type | output | 3 | 0 idle, 1 normal, 2 row-only, 3 counter, 4 hidden, 5 test entry |
| ref_stb | output | 1 | One-cycle pulse: refresh ref_row now |
| ref_row | output | ROW_W | Row to refresh, valid with ref_stb |
| ref_pair | output | 1 | Refresh also covers ref_row with top bit inverted |
| test_mode | output | 1 | Parallel test mode active |

## Verification
A counter that skips or repeats a value shows on the very next counter-type refresh: ref_row differs from the count of such refreshes since reset. A wrap fault shows once 4096 counter refreshes have been issued. A wrong sampled history of the column strobe or of write enable shows one cycle after the row strobe falls, as a wrong code. The three counter-type codes, row-only against counter refresh, and a missed test entry can all be told apart there. A stale test flag shows at the end of the next normal access. A row-only code that never becomes normal shows one sample after the column strobe falls.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    typedef enum logic [2:0] {
        CYC_IDLE   = 3'd0,
        CYC_NORMAL = 3'd1,
        CYC_ROWREF = 3'd2,
        CYC_CBR    = 3'd3,
        CYC_HIDDEN = 3'd4,
        CYC_TESTIN = 3'd5
    } cyc_e;

    // sampled strobe view handed from the sampler to the decoder
    typedef struct packed {
        logic ras_low;    // row strobe low in this sample
        logic ras_fall;   // high last sample, low now
        logic cas_low;    // either column lane low now
        logic cas_setup;  // column low last sample and now
        logic we_setup;   // write enable low last sample and now
        logic hidden;     // column held low since the last row strobe rise
    } strobe_s;

    function automatic cyc_e pick_type(strobe_s s);
        cyc_e t;
        if (!s.cas_setup)    t = CYC_ROWREF;
        else if (s.we_setup) t = CYC_TESTIN;
        else if (s.hidden)   t = CYC_HIDDEN;
        else                 t = CYC_CBR;
        return t;
    endfunction

    function automatic logic uses_counter(cyc_e t);
        return (t == CYC_CBR) || (t == CYC_HIDDEN) || (t == CYC_TESTIN);
    endfunction

endpackage

// File: rtl/dcc_strobe_sampler.sv
module dcc_strobe_sampler
    import dcc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ras_n,
    input  logic    cas_lo_n,
    input  logic    cas_hi_n,
    input  logic    we_n,
    output strobe_s smp
);

    logic ras_q;
    logic cas_low_q;
    logic we_low_q;
    logic hid_arm;
    logic cas_low_now;
    logic ras_rise;

    assign cas_low_now = !cas_lo_n || !cas_hi_n;
    assign ras_rise    = !ras_q && ras_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_q     <= 1'b1;
            cas_low_q <= 1'b0;
            we_low_q  <= 1'b0;
            hid_arm   <= 1'b0;
        end else begin
            ras_q     <= ras_n;
            cas_low_q <= cas_low_now;
            we_low_q  <= !we_n;
            if (!cas_low_now)
                hid_arm <= 1'b0;
            else if (ras_rise)
                hid_arm <= 1'b1;
            else if (ras_q && !ras_n)
                hid_arm <= 1'b0;
        end
    end

    always_comb begin
        smp.ras_low   = !ras_n;
        smp.ras_fall  = ras_q && !ras_n;
        smp.cas_low   = cas_low_now;
        smp.cas_setup = cas_low_now && cas_low_q;
        smp.we_setup  = !we_n && we_low_q;
        smp.hidden    = hid_arm;
    end

endmodule

// File: rtl/dcc_refresh_counter.sv
module dcc_refresh_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (adv)
            cnt <= cnt + 1'b1;
    end

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(cnt));

endmodule

// File: rtl/dcc_cycle_decoder.sv
module dcc_cycle_decoder
    import dcc_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  strobe_s          smp,
    input  logic [ROW_W-1:0] row_addr,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_adv,
    output cyc_e             cyc_type,
    output logic             ref_stb,
    output logic [ROW_W-1:0] ref_row,
    output logic             ref_pair,
    output logic             test_mode
);

    localparam logic PAIR_ON = (ROW_W > CNT_W);

    logic [ROW_W-1:0] cnt_row;
    cyc_e             fall_type;

    generate
        if (ROW_W > CNT_W) begin : g_pad
            assign cnt_row = {{(ROW_W-CNT_W){1'b0}}, cnt};
        end else begin : g_trim
            assign cnt_row = cnt[ROW_W-1:0];
        end
    endgenerate

    assign fall_type = pick_type(smp);
    assign cnt_adv   = smp.ras_fall && uses_counter(fall_type);

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_type  <= CYC_IDLE;
            ref_stb   <= 1'b0;
            ref_row   <= '0;
            ref_pair  <= 1'b0;
            test_mode <= 1'b0;
        end else begin
            ref_stb <= 1'b0;
            if (!smp.ras_low) begin
                cyc_type <= CYC_IDLE;
            end else if (smp.ras_fall) begin
                cyc_type <= fall_type;
                ref_stb  <= 1'b1;
                if (uses_counter(fall_type)) begin
                    ref_row  <= cnt_row;
                    ref_pair <= PAIR_ON;
                end else begin
                    ref_row  <= row_addr;
                    ref_pair <= 1'b0;
                end
                if (fall_type == CYC_TESTIN)
                    test_mode <= 1'b1;
            end else if (cyc_type == CYC_ROWREF && smp.cas_low) begin
                cyc_type  <= CYC_NORMAL;
                test_mode <= 1'b0;
            end
        end
    end

    // R9
    idle_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !smp.ras_low |=> cyc_type == CYC_IDLE);

    // R9
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (smp.ras_low && !smp.ras_fall && cyc_type != CYC_ROWREF) |=> $stable(cyc_type));

    // R2
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        ref_stb |=> !ref_stb);

    // R7
    tm_set_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(test_mode) |-> cyc_type == CYC_TESTIN);

    // R4
    normal_clears_tm_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_type == CYC_NORMAL |-> !test_mode);

    // R8
    tm_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_stb && cyc_type != CYC_TESTIN) |-> test_mode == $past(test_mode));

endmodule

// File: rtl/dram_cycle_classifier.sv
module dram_cycle_classifier
    import dcc_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ras_n,
    input  logic             cas_lo_n,
    input  logic             cas_hi_n,
    input  logic             we_n,
    input  logic [ROW_W-1:0] row_addr,
    output logic [2:0]       cyc_type,
    output logic             ref_stb,
    output logic [ROW_W-1:0] ref_row,
    output logic             ref_pair,
    output logic             test_mode
);

    strobe_s          smp;
    logic             cnt_adv;
    logic [CNT_W-1:0] cnt;
    cyc_e             dec_type;

    dcc_strobe_sampler u_sampler (
        .clk      (clk),
        .rst      (rst),
        .ras_n    (ras_n),
        .cas_lo_n (cas_lo_n),
        .cas_hi_n (cas_hi_n),
        .we_n     (we_n),
        .smp      (smp)
    );

    dcc_refresh_counter #(.CNT_W(CNT_W)) u_counter (
        .clk (clk),
        .rst (rst),
        .adv (cnt_adv),
        .cnt (cnt)
    );

    dcc_cycle_decoder #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_decoder (
        .clk       (clk),
        .rst       (rst),
        .smp       (smp),
        .row_addr  (row_addr),
        .cnt       (cnt),
        .cnt_adv   (cnt_adv),
        .cyc_type  (dec_type),
        .ref_stb   (ref_stb),
        .ref_row   (ref_row),
        .ref_pair  (ref_pair),
        .test_mode (test_mode)
    );

    assign cyc_type = dec_type;

endmodule

// File: tb/test_dram_cycle_classifier.sv
module test_dram_cycle_classifier;

    localparam int CLK_P = 10;
    localparam int ROW_W = 13;
    localparam int CNT_W = 12;

    localparam logic [2:0] T_IDLE = 3'd0, T_NORM = 3'd1, T_ROW = 3'd2,
                           T_CBR = 3'd3, T_HID = 3'd4, T_TEST = 3'd5;

    typedef struct packed {
        logic       cas_pre;
        logic       cas_fall;
        logic       cas_mid;
        logic       we_pre;
        logic       we_fall;
        logic       hi_only;
        logic [2:0] exp_fall;
        logic [2:0] exp_mid;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,T_CBR ,T_CBR },  // R2 counter refresh
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,T_ROW ,T_ROW },  // R3 row-only
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,T_ROW ,T_NORM},  // R4 normal access
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,T_ROW ,T_NORM},  // R5 late column strobe
        '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,T_TEST,T_TEST},  // R7 test entry
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,T_ROW ,T_ROW },  // R8 row-only keeps flag
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,T_CBR ,T_CBR },  // R8 counter keeps flag
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,T_CBR ,T_CBR },  // R7 late write enable
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,T_ROW ,T_NORM},  // R4 write clears flag
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,T_CBR ,T_CBR },  // R12 upper lane
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,T_ROW ,T_NORM},  // R12 upper lane
        '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,T_TEST,T_TEST}   // R12 upper lane test
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ras_n = 1'b1, cas_lo_n = 1'b1, cas_hi_n = 1'b1, we_n = 1'b1;
    logic [ROW_W-1:0] row_addr = '0;
    logic [2:0]       cyc_type;
    logic             ref_stb, ref_pair, test_mode;
    logic [ROW_W-1:0] ref_row;

    int n_run = 0;
    int n_fail = 0;

    logic [2:0]       o_fall_type, o_mid_type, o_idle_type;
    logic             o_fall_stb, o_mid_stb, o_fall_pair, o_tm;
    logic [ROW_W-1:0] o_fall_row;

    logic [CNT_W-1:0] cnt_m = '0;
    logic             tm_m  = 1'b0;

    dram_cycle_classifier #(.ROW_W(ROW_W), .CNT_W(CNT_W)) i_dram_cycle_classifier (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_lo_n(cas_lo_n), .cas_hi_n(cas_hi_n),
        .we_n(we_n), .row_addr(row_addr), .cyc_type(cyc_type), .ref_stb(ref_stb),
        .ref_row(ref_row), .ref_pair(ref_pair), .test_mode(test_mode)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic set_cas(input logic low, input logic hi_only);
        cas_hi_n = !low;
        cas_lo_n = !(low && !hi_only);
    endtask

    // one row strobe cycle of four samples; results land in o_*
    task automatic ras_cycle(input vec_t v, input logic [ROW_W-1:0] row);
        @(negedge clk);
        ras_n = 1'b1; set_cas(v.cas_pre, v.hi_only); we_n = !v.we_pre; row_addr = row;
        @(negedge clk);
        ras_n = 1'b0; set_cas(v.cas_fall, v.hi_only); we_n = !v.we_fall;
        @(negedge clk);
        o_fall_type = cyc_type; o_fall_stb = ref_stb; o_fall_row = ref_row; o_fall_pair = ref_pair;
        set_cas(v.cas_mid, v.hi_only); we_n = 1'b1;
        @(negedge clk);
        o_mid_type = cyc_type; o_mid_stb = ref_stb;
        ras_n = 1'b1; set_cas(1'b0, 1'b0); cas_lo_n = 1'b1; cas_hi_n = 1'b1;
        @(negedge clk);
        o_idle_type = cyc_type; o_tm = test_mode;
    endtask

    function automatic logic is_cnt(input logic [2:0] t);
        return (t == T_CBR) || (t == T_HID) || (t == T_TEST);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 code in reset", {13'd0, cyc_type}, 16'd0);
        chk("R1 strobe in reset", {15'd0, ref_stb}, 16'd0);
        chk("R1 test flag in reset", {15'd0, test_mode}, 16'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 code after reset", {13'd0, cyc_type}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [ROW_W-1:0] row, exp_row;
            logic exp_pair;
            v   = VECS[i];
            row = ROW_W'(13'h01A5 + i * 13'h0321);
            if (is_cnt(v.exp_fall)) begin
                exp_row  = {1'b0, cnt_m};   // R11 top bit 0 on counter rows
                exp_pair = 1'b1;
                cnt_m    = cnt_m + 1'b1;
            end else begin
                exp_row  = row;
                exp_pair = 1'b0;
            end
            if (v.exp_fall == T_TEST) tm_m = 1'b1;
            if (v.exp_mid == T_NORM)  tm_m = 1'b0;
            ras_cycle(v, row);
            chk($sformatf("R2/R3/R7 vec%0d fall code", i), {13'd0, o_fall_type}, {13'd0, v.exp_fall});
            chk($sformatf("R2 vec%0d fall strobe", i), {15'd0, o_fall_stb}, 16'd1);
            chk($sformatf("R3/R10 vec%0d refresh row", i), {3'd0, o_fall_row}, {3'd0, exp_row});
            chk($sformatf("R11 vec%0d pair flag", i), {15'd0, o_fall_pair}, {15'd0, exp_pair});
            chk($sformatf("R4/R5/R9 vec%0d mid code", i), {13'd0, o_mid_type}, {13'd0, v.exp_mid});
            chk($sformatf("R2 vec%0d strobe one cycle", i), {15'd0, o_mid_stb}, 16'd0);
            chk($sformatf("R9 vec%0d idle after rise", i), {13'd0, o_idle_type}, {13'd0, T_IDLE});
            chk($sformatf("R7/R8 vec%0d test flag", i), {15'd0, o_tm}, {15'd0, tm_m});
        end

        // R6 hidden refresh after a read with the column strobe held low
        @(negedge clk);
        ras_n = 1'b1; cas_lo_n = 1'b1; cas_hi_n = 1'b1; we_n = 1'b1; row_addr = 13'h0777;
        @(negedge clk);
        ras_n = 1'b0;
        @(negedge clk);
        cas_lo_n = 1'b0;
        @(negedge clk);
        chk("R4 read before hidden", {13'd0, cyc_type}, {13'd0, T_NORM});
        tm_m = 1'b0;
        ras_n = 1'b1;
        @(negedge clk);
        chk("R9 idle during hidden gap", {13'd0, cyc_type}, {13'd0, T_IDLE});
        ras_n = 1'b0;
        @(negedge clk);
        chk("R6 hidden code", {13'd0, cyc_type}, {13'd0, T_HID});
        chk("R6 hidden strobe", {15'd0, ref_stb}, 16'd1);
        chk("R6 hidden row", {3'd0, ref_row}, {3'd0, 1'b0, cnt_m});
        chk("R8 hidden keeps flag", {15'd0, test_mode}, {15'd0, tm_m});
        cnt_m = cnt_m + 1'b1;
        @(negedge clk);
        ras_n = 1'b1; cas_lo_n = 1'b1;
        @(negedge clk);

        // R10 wrap: 4096 counter refreshes bring the row back
        for (int k = 0; k < 4096; k++)
            ras_cycle(VECS[0], '0);
        ras_cycle(VECS[0], '0);
        chk("R10 row after wrap", {3'd0, o_fall_row}, {3'd0, 1'b0, cnt_m});
        chk("R10 code after wrap", {13'd0, o_fall_type}, {13'd0, T_CBR});

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule